// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits behind a receive parser and decides, from the destination MAC address alone, whether a frame is kept. An individual (unicast) address is compared against a bank of programmable exact-match entries. A group address (multicast or broadcast) is reduced to a CRC-derived index into a one-bit-per-bucket hash table. Every accepted frame is given a receive queue index. The index comes from the matching entry, or from a programmable default queue for frames accepted through the group path.

The frame payload never passes through the block, so frames of any length are handled the same way, jumbo frames included. The parser raises a one-cycle strobe with the address. The verdict appears two clock cycles later, together with a one-cycle result-valid pulse. Software programs the entries, the hash bits and the control fields through a write-only register port.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `res_valid`, `res_accept` and `res_queue` are 0, every exact entry is disabled, every hash bit is clear and every control bit is 0, so every frame is rejected.
- R2: A `da_valid` pulse sampled at clock edge k produces `res_valid` high for exactly the cycle after edge k+1, that is, 2 cycles after the strobe. Back-to-back strobes each produce their own result. Outside such a pulse, `res_accept` and `res_queue` are 0.
- R3: A destination whose group bit (`da[40]`, the LSB of the first byte on the wire, `da[47:40]`) is 0 is accepted when it equals an enabled exact entry. The result takes that entry's queue field. A disabled entry never matches.
- R4: When several enabled entries hold the same address, the lowest-numbered entry supplies the queue.
- R5: A destination with the group bit 0 that matches no enabled entry is rejected, whatever the hash table holds.
- R6: For a destination with the group bit 1, the hash index is bits [31:23] of a CRC-32 register. The register uses the reflected polynomial 0xEDB88320 and starts at all ones. It takes bytes `da[47:40]` first through `da[7:0]` last, each byte LSB first, with no final inversion. When the table bit at that index is 1, the frame is accepted with the default queue.
- R7: A destination with the group bit 1 whose hash bit is 0 is rejected, even when an enabled exact entry holds the same address.
- R8: The all-ones destination is accepted with the default queue when the broadcast-enable bit is 1, even if its hash bit is 0. When that bit is 0, it follows R6 and R7.
- R9: With the promiscuous bit set, every frame is accepted with queue 0.
- R10: A rejected result reports queue 0.
- R11: Register map, written when `cfg_we` is 1:
  - Address 0x00 is control: bit 0 promiscuous, bit 1 broadcast enable, bits [4:2] default queue.
  - Address 0x10+2i is entry i, address bits [31:0].
  - Address 0x11+2i is entry i: bits [15:0] are address bits [47:32], bit 16 is enable, bits [19:17] are the queue.
  - Address 0x40+w is hash word w: bit b holds bucket 32w+b.
  - A write is used by frames whose strobe is sampled at a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| da_valid | input | 1 | One-cycle strobe: destination address present |
| da | input | 48 | Destination MAC, first wire byte in [47:40] |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 7 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| res_valid | output | 1 | Result pulse, 2 cycles after `da_valid` |
| res_accept | output | 1 | Frame accepted |
| res_queue | output | 3 | Receive queue index |

## Verification
The bench builds the block with its defaults: eight exact entries, a 9-bit hash index (512 buckets) and eight queues. With eight entries, the bench can fill every slot, duplicate an address across a low and a high slot, and reach queue 7. The full 9-bit index lets the bench search for group addresses that land on bucket 0 and bucket 511, the first and last bits of the table. The reference model computes the CRC on its own and predicts the result pulse on every clock, so the idle cycles and back-to-back strobes are checked along with the frames.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
  localparam int MAC_W   = 48;
  localparam int CFG_AW  = 7;
  localparam int CFG_DW  = 32;
  localparam logic [CFG_AW-1:0] ADR_CTRL  = 7'h00;
  localparam logic [CFG_AW-1:0] ADR_EXACT = 7'h10;
  localparam logic [CFG_AW-1:0] ADR_HASH  = 7'h40;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam int CTL_PROMISC = 0;
  localparam int CTL_BCAST   = 1;
  localparam int CTL_DQ_LSB  = 2;
  localparam int ENT_EN      = 16;
  localparam int ENT_Q_LSB   = 17;
endpackage

// File: rtl/afilt_crc_hash.sv
module afilt_crc_hash
  import afilt_pkg::*;
#(
  parameter int HASH_W = 9
) (
  input  logic [MAC_W-1:0]  mac,
  output logic [HASH_W-1:0] idx
);
  localparam int NBYTES = MAC_W / 8;

  logic [31:0] crc;
  logic [7:0]  byte_v;

  always_comb begin
    crc    = 32'hFFFF_FFFF;
    byte_v = '0;
    for (int b = 0; b < NBYTES; b++) begin
      byte_v = mac[MAC_W-1-8*b -: 8];
      crc[7:0] = crc[7:0] ^ byte_v;
      for (int s = 0; s < 8; s++) begin
        if (crc[0]) crc = (crc >> 1) ^ CRC_POLY;
        else        crc = crc >> 1;
      end
    end
    idx = crc[31 -: HASH_W];
  end
endmodule

// File: rtl/afilt_exact_bank.sv
module afilt_exact_bank
  import afilt_pkg::*;
#(
  parameter int N_EXACT = 8,
  parameter int QW      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [MAC_W-1:0]  mac,
  output logic              hit,
  output logic [QW-1:0]     hit_q
);
  logic [N_EXACT-1:0] match;
  logic [QW-1:0]      ent_q [N_EXACT];

  for (genvar i = 0; i < N_EXACT; i++) begin : g_ent
    localparam logic [CFG_AW-1:0] ADR_LO = ADR_EXACT + CFG_AW'(2*i);
    localparam logic [CFG_AW-1:0] ADR_HI = ADR_EXACT + CFG_AW'(2*i + 1);
    logic [MAC_W-1:0] mac_q, mac_d;
    logic             en_q, en_d;
    logic [QW-1:0]    q_q, q_d;
    logic             we_lo, we_hi;

    assign we_lo = cfg_we && (cfg_addr == ADR_LO);
    assign we_hi = cfg_we && (cfg_addr == ADR_HI);

    always_comb begin
      mac_d = mac_q;
      en_d  = en_q;
      q_d   = q_q;
      if (we_lo) mac_d[31:0] = cfg_wdata;
      if (we_hi) begin
        mac_d[MAC_W-1:32] = cfg_wdata[15:0];
        en_d              = cfg_wdata[ENT_EN];
        q_d               = cfg_wdata[ENT_Q_LSB +: QW];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mac_q <= '0;
        en_q  <= 1'b0;
        q_q   <= '0;
      end else if (we_lo || we_hi) begin
        mac_q <= mac_d;
        en_q  <= en_d;
        q_q   <= q_d;
      end
    end

    assign match[i] = en_q && (mac_q == mac);
    assign ent_q[i] = q_q;
  end

  always_comb begin
    hit   = |match;
    hit_q = '0;
    for (int i = N_EXACT-1; i >= 0; i--) begin
      if (match[i]) hit_q = ent_q[i];
    end
  end
endmodule

// File: rtl/afilt_hash_table.sv
module afilt_hash_table
  import afilt_pkg::*;
#(
  parameter int HASH_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [HASH_W-1:0] idx,
  output logic              bit_set
);
  localparam int BUCKETS = 1 << HASH_W;
  localparam int WORDS   = BUCKETS / CFG_DW;

  logic [BUCKETS-1:0] tbl;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [CFG_AW-1:0] ADR_W = ADR_HASH + CFG_AW'(w);
    logic we_w;
    assign we_w = cfg_we && (cfg_addr == ADR_W);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tbl[w*CFG_DW +: CFG_DW] <= '0;
      else if (we_w) tbl[w*CFG_DW +: CFG_DW] <= cfg_wdata;
    end
  end

  assign bit_set = tbl[idx];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import afilt_pkg::*;
#(
  parameter int N_EXACT = 8,
  parameter int HASH_W  = 9,
  parameter int N_QUEUE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        da_valid,
  input  logic [47:0] da,
  input  logic        cfg_we,
  input  logic [6:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        res_valid,
  output logic        res_accept,
  output logic [2:0]  res_queue
);
  localparam int QW = $clog2(N_QUEUE);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_q = rst_sync[1];

  // control register
  logic          ctl_promisc, ctl_bcast;
  logic [QW-1:0] ctl_dq;
  logic          ctl_we;
  assign ctl_we = cfg_we && (cfg_addr == ADR_CTRL);

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      ctl_promisc <= 1'b0;
      ctl_bcast   <= 1'b0;
      ctl_dq      <= '0;
    end else if (ctl_we) begin
      ctl_promisc <= cfg_wdata[CTL_PROMISC];
      ctl_bcast   <= cfg_wdata[CTL_BCAST];
      ctl_dq      <= cfg_wdata[CTL_DQ_LSB +: QW];
    end
  end

  // lookups on the incoming address
  logic              ex_hit;
  logic [QW-1:0]     ex_q;
  logic [HASH_W-1:0] h_idx;
  logic              h_bit;

  afilt_exact_bank #(.N_EXACT(N_EXACT), .QW(QW)) u_exact (
    .clk(clk), .rst_n(rst_n_q), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mac(da), .hit(ex_hit), .hit_q(ex_q)
  );

  afilt_crc_hash #(.HASH_W(HASH_W)) u_crc (.mac(da), .idx(h_idx));

  afilt_hash_table #(.HASH_W(HASH_W)) u_tbl (
    .clk(clk), .rst_n(rst_n_q), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .idx(h_idx), .bit_set(h_bit)
  );

  // stage 1 registers
  logic          s1_v, s1_grp, s1_bc, s1_hit, s1_hbit;
  logic [QW-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      s1_v    <= 1'b0;
      s1_grp  <= 1'b0;
      s1_bc   <= 1'b0;
      s1_hit  <= 1'b0;
      s1_hbit <= 1'b0;
      s1_q    <= '0;
    end else begin
      s1_v <= da_valid;
      if (da_valid) begin
        s1_grp  <= da[40];
        s1_bc   <= &da;
        s1_hit  <= ex_hit;
        s1_hbit <= h_bit;
        s1_q    <= ex_q;
      end
    end
  end

  // stage 2 decision
  logic          acc_d;
  logic [QW-1:0] q_d;

  always_comb begin
    acc_d = 1'b0;
    q_d   = '0;
    if (s1_v) begin
      if (ctl_promisc) begin
        acc_d = 1'b1;
      end else if (!s1_grp) begin
        if (s1_hit) begin
          acc_d = 1'b1;
          q_d   = s1_q;
        end
      end else if ((s1_bc && ctl_bcast) || s1_hbit) begin
        acc_d = 1'b1;
        q_d   = ctl_dq;
      end
    end
  end

  logic [QW-1:0] res_q_r;
  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_q_r    <= '0;
    end else begin
      res_valid  <= s1_v;
      res_accept <= acc_d;
      res_q_r    <= q_d;
    end
  end

  assign res_queue = 3'(res_q_r);
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
  input logic       clk,
  input logic       rst_n_q,
  input logic       da_valid,
  input logic       ctl_promisc,
  input logic       res_valid,
  input logic       res_accept,
  input logic [2:0] res_queue
);
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n_q)
    da_valid |-> ##2 res_valid); // R2
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n_q)
    res_valid |-> $past(da_valid, 2)); // R2
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n_q)
    !res_valid |-> (!res_accept && res_queue == 3'd0)); // R2
  AST_REJECT_QUEUE_ZERO: assert property (@(posedge clk) disable iff (!rst_n_q)
    (res_valid && !res_accept) |-> res_queue == 3'd0); // R10
  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n_q)
    (res_valid && $past(ctl_promisc) && $past(res_valid == 1'b0 || 1'b1))
      |-> (res_accept && res_queue == 3'd0)); // R9
endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
  .clk(clk), .rst_n_q(rst_n_q), .da_valid(da_valid), .ctl_promisc(ctl_promisc),
  .res_valid(res_valid), .res_accept(res_accept), .res_queue(res_queue)
);

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        da_valid;
  logic [47:0] da;
  logic        cfg_we;
  logic [6:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        res_valid, res_accept;
  logic [2:0]  res_queue;

  always #2.5 clk = ~clk;

  rx_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .res_valid(res_valid), .res_accept(res_accept), .res_queue(res_queue)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic [47:0] m_mac [8];
  logic        m_en  [8];
  logic [2:0]  m_q   [8];
  logic        m_tbl [512];
  logic        m_prom, m_bc;
  logic [2:0]  m_dq;

  // expected-result pipeline
  logic       e0_v, e0_a, e1_v, e1_a;
  logic [2:0] e0_q, e1_q;
  string      e0_t, e1_t;

  function automatic int ref_hash(input logic [47:0] mac);
    logic [31:0] r;
    r = 32'hFFFFFFFF;
    for (int k = 0; k < 48; k++) begin
      logic inb, fb;
      inb = mac[47 - 8*(k/8) - 7 + (k%8)];
      fb  = r[0] ^ inb;
      r   = {1'b0, r[31:1]};
      if (fb) r = r ^ 32'hEDB88320;
    end
    return int'(r[31:23]);
  endfunction

  task automatic ref_eval(input logic [47:0] mac, output logic a, output logic [2:0] q);
    a = 1'b0; q = 3'd0;
    if (m_prom) begin
      a = 1'b1;
    end else if (!mac[40]) begin
      for (int i = 7; i >= 0; i--)
        if (m_en[i] && m_mac[i] == mac) begin a = 1'b1; q = m_q[i]; end
    end else if ((mac == 48'hFFFF_FFFF_FFFF && m_bc) || m_tbl[ref_hash(mac)]) begin
      a = 1'b1; q = m_dq;
    end
  endtask

  task automatic ref_write(input logic [6:0] a, input logic [31:0] d);
    if (a == 7'h00) begin
      m_prom = d[0]; m_bc = d[1]; m_dq = d[4:2];
    end else if (a >= 7'h10 && a < 7'h20) begin
      if (a[0] == 1'b0) m_mac[(a-7'h10)/2][31:0] = d;
      else begin
        m_mac[(a-7'h10)/2][47:32] = d[15:0];
        m_en[(a-7'h10)/2] = d[16];
        m_q[(a-7'h10)/2]  = d[19:17];
      end
    end else if (a >= 7'h40 && a < 7'h50) begin
      for (int b = 0; b < 32; b++) m_tbl[(a-7'h40)*32 + b] = d[b];
    end
  endtask

  // one clock: compare, advance the pipeline, drive the next inputs
  task automatic tick(input logic v, input logic [47:0] mac, input string tag,
                      input logic we, input logic [6:0] a, input logic [31:0] d);
    logic ea; logic [2:0] eq;
    @(negedge clk);
    n_chk++;
    if (res_valid !== e1_v || res_accept !== e1_a || res_queue !== e1_q) begin
      n_bad++;
      $display("FAIL %s: got v=%0b acc=%0b q=%0d, expected v=%0b acc=%0b q=%0d",
               e1_t, res_valid, res_accept, res_queue, e1_v, e1_a, e1_q);
    end
    e1_v = e0_v; e1_a = e0_a; e1_q = e0_q; e1_t = e0_t;
    ea = 1'b0; eq = 3'd0;
    if (v) ref_eval(mac, ea, eq);
    e0_v = v; e0_a = ea; e0_q = eq; e0_t = v ? tag : "R2";
    da_valid = v; da = mac; cfg_we = we; cfg_addr = a; cfg_wdata = d;
    if (we) ref_write(a, d);
  endtask

  task automatic frame(input logic [47:0] mac, input string tag);
    tick(1'b1, mac, tag, 1'b0, 7'h0, 32'h0);
  endtask
  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    tick(1'b0, 48'h0, "R11", 1'b1, a, d);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 48'h0, "R2", 1'b0, 7'h0, 32'h0);
  endtask
  task automatic set_entry(input int i, input logic [47:0] mac, input logic en, input logic [2:0] q);
    wr(7'(16 + 2*i), mac[31:0]);
    wr(7'(17 + 2*i), {12'h0, q, en, mac[47:32]});
  endtask

  function automatic logic [47:0] find_mac(input logic [47:0] base, input int target);
    for (int k = 0; k < 65536; k++) begin
      logic [47:0] c;
      c = base | 48'(k);
      if (ref_hash(c) == target) return c;
    end
    return base;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] g0, g511, gclr, u_h0, bc;
    for (int i = 0; i < 8; i++) begin m_mac[i] = '0; m_en[i] = 1'b0; m_q[i] = '0; end
    for (int i = 0; i < 512; i++) m_tbl[i] = 1'b0;
    m_prom = 0; m_bc = 0; m_dq = 0;
    e0_v = 0; e0_a = 0; e0_q = 0; e1_v = 0; e1_a = 0; e1_q = 0; e0_t = "R1"; e1_t = "R1";
    da_valid = 0; da = '0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_chk++; // R1 outputs held low in reset
    if (res_valid !== 1'b0 || res_accept !== 1'b0 || res_queue !== 3'd0) begin
      n_bad++;
      $display("FAIL R1: got v=%0b acc=%0b q=%0d, expected 0 0 0", res_valid, res_accept, res_queue);
    end
    rst_n = 1'b1;
    idle(4);
    // R1: nothing programmed, everything rejected
    frame(48'h0A11_2233_4400, "R1");
    frame(48'hFFFF_FFFF_FFFF, "R1");
    frame(48'h0100_5E00_0001, "R1");
    idle(3);

    // exact entries, queue = 7-i
    for (int i = 0; i < 8; i++) set_entry(i, 48'h0A11_2233_4400 | 48'(i), 1'b1, 3'(7 - i));
    set_entry(6, 48'h0A11_2233_4402, 1'b1, 3'd1);           // duplicate of entry 2
    set_entry(5, 48'h0A11_2233_4405, 1'b0, 3'd2);           // disabled
    idle(2);
    frame(48'h0A11_2233_4400, "R3");
    frame(48'h0A11_2233_4407, "R3");                        // queue 0 via entry 7
    frame(48'h0A11_2233_4403, "R3");
    frame(48'h0A11_2233_4402, "R4");
    frame(48'h0A11_2233_4405, "R3");                        // disabled entry
    idle(1);
    frame(48'h0A11_2233_4499, "R5");
    frame(48'h0A11_2233_4401, "R2");
    idle(3);

    // group path
    g0   = find_mac(48'h0100_5E00_0000, 0);
    g511 = find_mac(48'h0100_5E00_0000, 511);
    gclr = find_mac(48'h0100_5E01_0000, 7);
    u_h0 = find_mac(48'h0200_0000_0000, 0);
    wr(7'h00, 32'h0000_0014);                               // default queue 5
    wr(7'h40, 32'h0000_0001);                               // bucket 0
    wr(7'h4F, 32'h8000_0000);                               // bucket 511
    set_entry(7, gclr, 1'b1, 3'd6);
    idle(2);
    frame(g0, "R6");
    frame(g511, "R6");
    frame(gclr, "R7");
    frame(u_h0, "R5");
    idle(2);

    // broadcast
    bc = 48'hFFFF_FFFF_FFFF;
    frame(bc, "R8");
    idle(2);
    wr(7'h00, 32'h0000_001E);                               // bcast on, queue 7
    idle(1);
    frame(bc, "R8");
    frame(g511, "R6");
    idle(2);
    wr(7'h4F, 32'h0000_0000);
    idle(1);
    frame(g511, "R7");
    idle(2);

    // promiscuous
    wr(7'h00, 32'h0000_001D);
    idle(1);
    frame(48'h0A11_2233_4403, "R9");
    frame(48'h0A11_2233_4499, "R9");
    frame(gclr, "R9");
    frame(bc, "R9");
    idle(2);
    wr(7'h00, 32'h0000_0000);
    idle(1);
    frame(48'h0A11_2233_4499, "R10");
    frame(bc, "R10");
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule